// File: doc/BRIEF.md
# Zero-Overhead Loop Controller

This block is the hardware loop unit placed next to the program counter of a small 32-bit core. Two setup commands arm it. A counted setup sends the PC of the setup instruction, a 17-bit signed displacement and an iteration count. An endless setup sends only the PC and the displacement. From these the block derives a loop-begin address (setup PC + 4) and a loop-end address (setup PC + sign-extended displacement). Bit 0 of the loop-end register is a mode tag: 0 marks a counted loop and 1 marks an endless loop.

On every valid fetch, the block compares the fetch PC with the loop end, ignoring bit 0. On a hit while the loop is still live, it raises a redirect strobe in the same cycle and supplies the loop-begin address as the next fetch target. A counted loop spends one count per redirect. When the count is zero it lets execution fall through. An endless loop redirects on every hit and never touches the count. The three registers can also be read and written through a small control-register port.

The controller is a three-state machine. **ZS_IDLE** is entered on reset and never redirects. **ZS_COUNTED** redirects on a hit while the count is nonzero. **ZS_ENDLESS** redirects on every hit. The transitions are:
- **T_ARM_COUNTED**: a counted setup, or a control write of the end register with bit 0 = 0, goes from any state to ZS_COUNTED.
- **T_ARM_ENDLESS**: an endless setup, or a control write of the end register with bit 0 = 1, goes from any state to ZS_ENDLESS.
- **T_RESET**: a synchronous reset goes to ZS_IDLE.

Top module: `zol_ctrl`

## Requirements
- R1: Synchronous reset clears the begin, end and count registers and the endless flag, and enters ZS_IDLE. In ZS_IDLE no redirect is raised, even if the fetch PC equals the end register.
- R2: A counted setup loads begin = PC + 4, end = PC + sign-extended displacement with bit 0 forced to 0, and count = the supplied value. It also clears the endless flag. All of these are visible on the next cycle.
- R3: An endless setup loads begin = PC + 4 and end = PC + sign-extended displacement with bit 0 forced to 1. It sets the endless flag and leaves the count register holding its previous value.
- R4: In ZS_COUNTED, a valid fetch whose PC matches the end register with a nonzero count raises redirect in that same cycle, with target = begin. The count drops by one on the next cycle.
- R5: In ZS_COUNTED with a count of zero, a matching fetch raises no redirect and the count stays at zero.
- R6: In ZS_ENDLESS, every matching valid fetch redirects to begin, and the count is never changed.
- R7: A fetch with the valid input low, or a fetch whose PC does not match, raises no redirect and leaves the count unchanged.
- R8: Control writes use select 0 = begin, 1 = end, 2 = count and 3 = unused. A write to begin, end or count is visible on the next cycle. A write to the end register moves the state to ZS_ENDLESS if bit 0 of the written value is 1, and to ZS_COUNTED if it is 0. A write to select 3 changes nothing, and select 3 reads as zero.
- R9: The update order is fixed, highest first: counted setup, then endless setup, then control write, then loop decrement. When both setups arrive together, the counted setup wins.
- R10: Bit 0 of the fetch PC is ignored in the compare. A negative displacement is sign-extended from bit 16.
- R11: The control read data shows the selected register combinationally, in the same cycle as the select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_setup_i | input | 1 | Counted-loop setup command |
| inf_setup_i | input | 1 | Endless-loop setup command |
| setup_pc_i | input | 32 | PC of the setup instruction |
| setup_disp_i | input | 17 | Signed displacement to the loop end |
| setup_count_i | input | 32 | Iteration count for a counted setup |
| fetch_valid_i | input | 1 | Fetch PC is valid this cycle |
| fetch_pc_i | input | 32 | Current fetch PC |
| csr_we_i | input | 1 | Control-register write enable |
| csr_sel_i | input | 2 | Register select: 0 begin, 1 end, 2 count, 3 unused |
| csr_wdata_i | input | 32 | Control-register write data |
| csr_rdata_o | output | 32 | Selected register, combinational |
| endless_o | output | 1 | High while in ZS_ENDLESS |
| redirect_o | output | 1 | Redirect the next fetch |
| redirect_pc_o | output | 32 | Redirect target (loop begin) |

## Verification
The redirect strobe, the redirect target and the control read data are combinational. They are due in the same cycle as the fetch PC or the select. The bench drives inputs on the falling edge and samples these outputs 1 ns later, before the next rising edge.

Every register result is due one rising edge after its command. This covers a setup, a control write, a count decrement and a mode change. The bench therefore checks these one full cycle after the command, on the following falling edge, after it has removed the command.

// File: rtl/zol_pkg.sv
package zol_pkg;
    typedef enum logic [1:0] {
        ZS_IDLE    = 2'd0,
        ZS_COUNTED = 2'd1,
        ZS_ENDLESS = 2'd2
    } zol_state_e;

    typedef enum logic [1:0] {
        CSR_BEGIN = 2'd0,
        CSR_END   = 2'd1,
        CSR_COUNT = 2'd2,
        CSR_NONE  = 2'd3
    } csr_sel_e;
endpackage

// File: rtl/zol_addr_gen.sv
// Derives loop begin and tagged loop end from a setup command.
module zol_addr_gen #(
    parameter int AW   = 32,
    parameter int DW   = 17,
    parameter int STEP = 4
) (
    input  logic [AW-1:0] pc_i,
    input  logic [DW-1:0] disp_i,
    input  logic          endless_i,
    output logic [AW-1:0] begin_o,
    output logic [AW-1:0] end_o
);
    localparam int EXT = AW - DW;

    logic [AW-1:0] disp_sx;
    logic [AW-1:0] sum;

    always_comb begin
        disp_sx = {{EXT{disp_i[DW-1]}}, disp_i};
        sum     = pc_i + disp_sx;
        begin_o = pc_i + AW'(STEP);
        end_o   = {sum[AW-1:1], endless_i};
    end
endmodule

// File: rtl/zol_match.sv
// Compares the fetch PC with the loop end, ignoring bit 0.
module zol_match #(
    parameter int AW = 32,
    parameter int CW = 32
) (
    input  logic          fetch_valid_i,
    input  logic [AW-1:0] fetch_pc_i,
    input  logic [AW-1:0] end_i,
    input  logic [CW-1:0] count_i,
    output logic          hit_o,
    output logic          cnt_zero_o
);
    always_comb begin
        hit_o      = fetch_valid_i && (fetch_pc_i[AW-1:1] == end_i[AW-1:1]);
        cnt_zero_o = (count_i == '0);
    end
endmodule

// File: rtl/zol_ctrl.sv
module zol_ctrl
    import zol_pkg::*;
#(
    parameter int AW   = 32,
    parameter int DW   = 17,
    parameter int CW   = 32,
    parameter int STEP = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cnt_setup_i,
    input  logic          inf_setup_i,
    input  logic [AW-1:0] setup_pc_i,
    input  logic [DW-1:0] setup_disp_i,
    input  logic [CW-1:0] setup_count_i,
    input  logic          fetch_valid_i,
    input  logic [AW-1:0] fetch_pc_i,
    input  logic          csr_we_i,
    input  logic [1:0]    csr_sel_i,
    input  logic [AW-1:0] csr_wdata_i,
    output logic [AW-1:0] csr_rdata_o,
    output logic          endless_o,
    output logic          redirect_o,
    output logic [AW-1:0] redirect_pc_o
);
    zol_state_e    state_q, state_d;
    logic [AW-1:0] begin_q, end_q;
    logic [CW-1:0] cnt_q;
    logic [AW-1:0] gen_begin, gen_end;
    logic          hit, cnt_zero, take, dec;
    logic          any_setup, wr_begin, wr_end, wr_count;

    assign any_setup = cnt_setup_i || inf_setup_i;
    assign wr_begin  = csr_we_i && (csr_sel_i == CSR_BEGIN);
    assign wr_end    = csr_we_i && (csr_sel_i == CSR_END);
    assign wr_count  = csr_we_i && (csr_sel_i == CSR_COUNT);

    // A counted setup wins over an endless one, so the tag follows it.
    zol_addr_gen #(.AW(AW), .DW(DW), .STEP(STEP)) u_gen (
        .pc_i      (setup_pc_i),
        .disp_i    (setup_disp_i),
        .endless_i (!cnt_setup_i),
        .begin_o   (gen_begin),
        .end_o     (gen_end)
    );

    zol_match #(.AW(AW), .CW(CW)) u_match (
        .fetch_valid_i (fetch_valid_i),
        .fetch_pc_i    (fetch_pc_i),
        .end_i         (end_q),
        .count_i       (cnt_q),
        .hit_o         (hit),
        .cnt_zero_o    (cnt_zero)
    );

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        if (cnt_setup_i)
            state_d = ZS_COUNTED;
        else if (inf_setup_i)
            state_d = ZS_ENDLESS;
        else if (wr_end)
            state_d = csr_wdata_i[0] ? ZS_ENDLESS : ZS_COUNTED;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ZS_IDLE;
        else
            state_q <= state_d;
    end

    // Output process: redirect decision per state.
    always_comb begin
        take = 1'b0;
        dec  = 1'b0;
        unique case (state_q)
            ZS_IDLE: begin
                take = 1'b0;
            end
            ZS_COUNTED: begin
                take = hit && !cnt_zero;
                dec  = take;
            end
            ZS_ENDLESS: begin
                take = hit;
            end
            default: begin
                take = 1'b0;
            end
        endcase
        redirect_o    = take;
        redirect_pc_o = begin_q;
        endless_o     = (state_q == ZS_ENDLESS);
    end

    // Loop registers.
    always_ff @(posedge clk) begin
        if (rst) begin
            begin_q <= '0;
            end_q   <= '0;
            cnt_q   <= '0;
        end else begin
            if (any_setup) begin
                begin_q <= gen_begin;
                end_q   <= gen_end;
            end else begin
                if (wr_begin) begin_q <= csr_wdata_i;
                if (wr_end)   end_q   <= csr_wdata_i;
            end

            if (cnt_setup_i)
                cnt_q <= setup_count_i;
            else if (inf_setup_i)
                cnt_q <= cnt_q;
            else if (wr_count)
                cnt_q <= csr_wdata_i[CW-1:0];
            else if (dec)
                cnt_q <= cnt_q - CW'(1);
        end
    end

    // Control read path.
    always_comb begin
        unique case (csr_sel_i)
            CSR_BEGIN: csr_rdata_o = begin_q;
            CSR_END:   csr_rdata_o = end_q;
            CSR_COUNT: csr_rdata_o = AW'(cnt_q);
            default:   csr_rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/zol_ctrl_chk.sv
module zol_ctrl_chk #(
    parameter int AW   = 32,
    parameter int CW   = 32,
    parameter int STEP = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          cnt_setup_i,
    input logic          inf_setup_i,
    input logic [AW-1:0] setup_pc_i,
    input logic          fetch_valid_i,
    input logic          csr_we_i,
    input logic [1:0]    csr_sel_i,
    input logic [AW-1:0] csr_wdata_i,
    input logic          endless_o,
    input logic          redirect_o,
    input logic [AW-1:0] begin_q,
    input logic [AW-1:0] end_q,
    input logic [CW-1:0] cnt_q
);
    logic no_cnt_wr;
    assign no_cnt_wr = !(csr_we_i && csr_sel_i == 2'd2);

    a_r2_begin_load: assert property (@(posedge clk) disable iff (rst)
        (cnt_setup_i || inf_setup_i) |=> begin_q == $past(setup_pc_i) + AW'(STEP));

    a_r2_counted_tag: assert property (@(posedge clk) disable iff (rst)
        cnt_setup_i |=> (!endless_o && !end_q[0]));

    a_r3_endless_tag: assert property (@(posedge clk) disable iff (rst)
        (inf_setup_i && !cnt_setup_i) |=> (endless_o && end_q[0]));

    a_r4_decrement: assert property (@(posedge clk) disable iff (rst)
        (redirect_o && !endless_o && !cnt_setup_i && !inf_setup_i && no_cnt_wr)
        |=> cnt_q == $past(cnt_q) - CW'(1));

    a_r5_zero_falls_through: assert property (@(posedge clk) disable iff (rst)
        (!endless_o && cnt_q == '0) |-> !redirect_o);

    a_r6_endless_count_kept: assert property (@(posedge clk) disable iff (rst)
        (redirect_o && endless_o && !cnt_setup_i && no_cnt_wr) |=> $stable(cnt_q));

    a_r7_no_fetch_no_redirect: assert property (@(posedge clk) disable iff (rst)
        !fetch_valid_i |-> !redirect_o);

    a_r8_begin_write: assert property (@(posedge clk) disable iff (rst)
        (csr_we_i && csr_sel_i == 2'd0 && !cnt_setup_i && !inf_setup_i)
        |=> begin_q == $past(csr_wdata_i));
endmodule

bind zol_ctrl zol_ctrl_chk #(.AW(AW), .CW(CW), .STEP(STEP)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .cnt_setup_i   (cnt_setup_i),
    .inf_setup_i   (inf_setup_i),
    .setup_pc_i    (setup_pc_i),
    .fetch_valid_i (fetch_valid_i),
    .csr_we_i      (csr_we_i),
    .csr_sel_i     (csr_sel_i),
    .csr_wdata_i   (csr_wdata_i),
    .endless_o     (endless_o),
    .redirect_o    (redirect_o),
    .begin_q       (begin_q),
    .end_q         (end_q),
    .cnt_q         (cnt_q)
);

// File: tb/tb_zol_ctrl.sv
`timescale 1ns/1ps
module tb_zol_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cnt_setup_i = 1'b0, inf_setup_i = 1'b0;
    logic [31:0] setup_pc_i = '0;
    logic [16:0] setup_disp_i = '0;
    logic [31:0] setup_count_i = '0;
    logic        fetch_valid_i = 1'b0;
    logic [31:0] fetch_pc_i = '0;
    logic        csr_we_i = 1'b0;
    logic [1:0]  csr_sel_i = '0;
    logic [31:0] csr_wdata_i = '0;
    logic [31:0] csr_rdata_o, redirect_pc_o;
    logic        endless_o, redirect_o;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    zol_ctrl dut (
        .clk(clk), .rst(rst),
        .cnt_setup_i(cnt_setup_i), .inf_setup_i(inf_setup_i),
        .setup_pc_i(setup_pc_i), .setup_disp_i(setup_disp_i),
        .setup_count_i(setup_count_i),
        .fetch_valid_i(fetch_valid_i), .fetch_pc_i(fetch_pc_i),
        .csr_we_i(csr_we_i), .csr_sel_i(csr_sel_i), .csr_wdata_i(csr_wdata_i),
        .csr_rdata_o(csr_rdata_o), .endless_o(endless_o),
        .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd(input logic [1:0] s, output logic [31:0] v);
        csr_sel_i = s;
        #1;
        v = csr_rdata_o;
    endtask

    task automatic regs(input string req, input logic [31:0] b, input logic [31:0] e,
                        input logic [31:0] c, input logic m);
        logic [31:0] v;
        rd(2'd0, v); chk({req, " begin"}, v, b);
        rd(2'd1, v); chk({req, " end"}, v, e);
        rd(2'd2, v); chk({req, " count"}, v, c);
        chk({req, " endless"}, 32'(endless_o), 32'(m));
    endtask

    task automatic setup(input logic cnt, input logic inf, input logic [31:0] pc,
                         input logic [16:0] d, input logic [31:0] c);
        cnt_setup_i = cnt; inf_setup_i = inf;
        setup_pc_i = pc; setup_disp_i = d; setup_count_i = c;
        cyc();
        cnt_setup_i = 0; inf_setup_i = 0;
    endtask

    task automatic csr_wr(input logic [1:0] s, input logic [31:0] d);
        csr_we_i = 1; csr_sel_i = s; csr_wdata_i = d;
        cyc();
        csr_we_i = 0;
    endtask

    // Drive a fetch, check the same-cycle redirect, then advance one cycle.
    task automatic fetch(input string req, input logic v, input logic [31:0] pc,
                         input logic exp_r, input logic [31:0] exp_t);
        fetch_valid_i = v; fetch_pc_i = pc;
        #1;
        chk({req, " redirect"}, 32'(redirect_o), 32'(exp_r));
        if (exp_r) chk({req, " target"}, redirect_pc_o, exp_t);
        cyc();
        fetch_valid_i = 0;
    endtask

    task automatic t_reset();
        rst = 1;
        repeat (3) cyc();
        rst = 0;
        regs("R1", 0, 0, 0, 0);
        fetch("R1 idle", 1, 32'h0, 0, 0);
    endtask

    task automatic t_counted();
        setup(1, 0, 32'h1000, 17'h00040, 2);
        regs("R2", 32'h1004, 32'h1040, 2, 0);
        fetch("R4 first", 1, 32'h1040, 1, 32'h1004);
        regs("R4", 32'h1004, 32'h1040, 1, 0);
        fetch("R10 bit0", 1, 32'h1041, 1, 32'h1004);
        regs("R10", 32'h1004, 32'h1040, 0, 0);
        fetch("R5 zero", 1, 32'h1040, 0, 0);
        regs("R5", 32'h1004, 32'h1040, 0, 0);
    endtask

    task automatic t_nomatch();
        setup(1, 0, 32'h1000, 17'h00040, 3);
        fetch("R7 miss", 1, 32'h1044, 0, 0);
        fetch("R7 invalid", 0, 32'h1040, 0, 0);
        regs("R7", 32'h1004, 32'h1040, 3, 0);
    endtask

    task automatic t_negdisp();
        setup(1, 0, 32'h2000, 17'h1FFF0, 1);
        regs("R10 neg", 32'h2004, 32'h1FF0, 1, 0);
    endtask

    task automatic t_endless();
        setup(0, 1, 32'h3000, 17'h00020, 32'hDEAD);
        regs("R3", 32'h3004, 32'h3021, 1, 1);
        for (int i = 0; i < 3; i++)
            fetch("R6 loop", 1, 32'h3020, 1, 32'h3004);
        regs("R6", 32'h3004, 32'h3021, 1, 1);
    endtask

    task automatic t_csr();
        logic [31:0] v;
        csr_wr(2'd0, 32'h500);
        csr_wr(2'd1, 32'h600);
        csr_wr(2'd2, 32'h1);
        regs("R8", 32'h500, 32'h600, 1, 0);
        fetch("R8 loop", 1, 32'h600, 1, 32'h500);
        csr_wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd3, v); chk("R11 unused read", v, 0);
        regs("R8 unused write", 32'h500, 32'h600, 0, 0);
        csr_wr(2'd1, 32'h601);
        chk("R8 end tag", 32'(endless_o), 1);
        rd(2'd1, v); chk("R11 end read", v, 32'h601);
    endtask

    task automatic t_prio();
        setup(1, 1, 32'h4000, 17'h00010, 5);
        regs("R9 both", 32'h4004, 32'h4010, 5, 0);
        csr_we_i = 1; csr_sel_i = 2'd2; csr_wdata_i = 32'h99;
        setup(1, 0, 32'h4000, 17'h00010, 7);
        csr_we_i = 0;
        regs("R9 setup>csr", 32'h4004, 32'h4010, 7, 0);
        csr_we_i = 1; csr_sel_i = 2'd2; csr_wdata_i = 32'h33;
        fetch_valid_i = 1; fetch_pc_i = 32'h4010;
        #1; chk("R9 redirect", 32'(redirect_o), 1);
        cyc();
        csr_we_i = 0; fetch_valid_i = 0;
        regs("R9 csr>dec", 32'h4004, 32'h4010, 32'h33, 0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_counted();
        t_nomatch();
        t_negdisp();
        t_endless();
        t_csr();
        t_prio();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule